// File: doc/BRIEF.md
# Warm-Start Power-Up Sequencer

This block runs the warm-start phase of a power-management controller. It starts when a turn-on request arrives while the controller sits in its low-power user-off state. First it waits through a fixed initialisation window of 32 kHz ticks. At the end of that window it latches the configuration straps, but only once the supply-ready input confirms that the input supply is good. It then switches on the buck switchers and the linear regulators one per time slot, so that the inrush current is spread out.

Switchers that were flagged to stay running through user-off are never turned off on the way in. Each switcher gets a one-cycle load strobe in its own slot, telling it to reload the default settings selected by the latched straps. A reset timer starts on entry and keeps the system reset low and the processor reset high. Warm start ends at whichever comes later: the end of the sequence or the expiry of the timer. At that point the block releases the system reset, fires a one-cycle warm-start interrupt and hands control to the watchdog state. It stays there until the next reset.

All counting is done in ticks of the `tick` input, a one-cycle strobe at 32.768 kHz in the system clock domain. The 8.0 ms window is 262 ticks.

Top module: `ws_warm_seq`

## Requirements
- R1: The block leaves idle only on a clock edge where `turn_on` and `user_off` are both high; in every other state `turn_on` has no effect.
- R2: After entry the block stays in initialisation until `INIT_TICKS` ticks (default 262) have been counted and `supply_ok` is high. It leaves on the first clock edge where both are true. On that edge `straps` is captured onto `dflt_sel`, which is 0 after reset.
- R3: Outputs are switched on one per slot in a fixed order: switchers 0 to `NSW-1`, then regulators 0 to `NREG-1`. Output 0 turns on when initialisation ends. Each later output turns on once the previous slot has counted `slot_ticks` ticks. No two outputs ever turn on in the same cycle.
- R4: In idle, `sw_en` follows `keep_on`. From entry onward, every switcher whose `keep_on` bit was set at entry stays enabled, whatever `keep_on` does later.
- R5: In the cycle after switcher k's slot begins, `sw_load` is high for switcher k only, for exactly one cycle. It is zero at all other times.
- R6: `sys_rst_n` is low in every state except the final hand-over state. `mcu_rst_n` is always high.
- R7: In idle, `clk32_out` follows `clk32_req`. After entry it holds the value `clk32_req` had at entry.
- R8: The reset timer counts ticks from entry and is full after `RST_TICKS` ticks. When the sequence is done and the timer is full, `sys_rst_n` and `wdog_go` rise, and `warm_irq` is high for that first cycle only.
- R9: A low `rst_n` at a clock edge returns the block to idle. All enables, strobes, the interrupt and the latched values are cleared.
- R10: `slot_ticks` is captured at entry. Changing it during warm start does not change the slot length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 32.768 kHz tick strobe |
| turn_on | input | 1 | Turn-on request |
| user_off | input | 1 | High while the controller is in user-off |
| supply_ok | input | 1 | Input supply qualified |
| keep_on | input | NSW | Per-switcher stay-on-in-user-off flags |
| straps | input | STRAPW | Default-setting configuration straps |
| slot_ticks | input | SLOTW | Ticks per sequencer slot |
| clk32_req | input | 1 | 32 kHz processor clock enabled |
| ws_active | output | 1 | Warm start in progress |
| sw_en | output | NSW | Switcher enables |
| reg_en | output | NREG | Regulator enables |
| sw_load | output | NSW | One-cycle reload-defaults strobe per switcher |
| dflt_sel | output | STRAPW | Latched strap value selecting defaults |
| sys_rst_n | output | 1 | System reset, active low |
| mcu_rst_n | output | 1 | Processor reset, active low |
| clk32_out | output | 1 | 32 kHz processor clock enable |
| warm_irq | output | 1 | Warm-start interrupt pulse |
| wdog_go | output | 1 | Hand-over to the watchdog state |

## Verification
The assertions assume that `tick` is a synchronous strobe of at most one cycle per tick. They also assume that `slot_ticks` is at least 1 when entry happens; a value of 0 collapses each slot to a single cycle. The stimulus drives every input a fixed delay after the rising edge and draws `tick` either as a constant strobe or as a random 50% pattern. It also holds `supply_ok` low past the end of the window to stretch initialisation. Other runs wiggle `turn_on`, `keep_on`, `slot_ticks` and `clk32_req` during warm start, to confirm that none of them reaches the outputs. Slot lengths are chosen so that the sequence ends sometimes before and sometimes after the reset timer expires.

// File: rtl/ws_pkg.sv
// Shared types for the warm-start sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ws_pkg;
    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_INIT  = 3'd1,
        WS_SEQ   = 3'd2,
        WS_RWAIT = 3'd3,
        WS_DONE  = 3'd4
    } ws_state_e;
endpackage

// File: rtl/ws_tick_timer.sv
// Saturating tick counter: counts tick strobes from zero up to limit.
// full is high while the count equals limit. Assumes limit is held
// steady while counting.
module ws_tick_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          full
);
    logic [CW-1:0] cnt;

    // count ticks, clear on request, stop at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick && (cnt < limit)) cnt <= cnt + 1'b1;
    end

    assign full = (cnt == limit);
endmodule

// File: rtl/ws_enable_chain.sv
// Sticky per-output enable bits set one at a time by index, plus a
// one-cycle load strobe for the first NSW (switcher) positions.
// Assumes at most one step per cycle.
module ws_enable_chain #(
    parameter int N   = 8,
    parameter int NSW = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  en,
    output logic [NSW-1:0] load
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam logic [IW-1:0] MY_IDX = IW'(i);

        // set this enable when its slot opens, clear in idle
        always_ff @(posedge clk) begin
            if (!rst_n || clr) en[i] <= 1'b0;
            else if (step && idx == MY_IDX) en[i] <= 1'b1;
        end

        if (i < NSW) begin : g_load
            // strobe the reload for this switcher in the cycle after its slot opens
            always_ff @(posedge clk) begin
                if (!rst_n) load[i] <= 1'b0;
                else load[i] <= step && (idx == MY_IDX);
            end
        end
    end
endmodule

// File: rtl/ws_warm_seq.sv
// Warm-start sequencer top. It walks through idle, initialisation
// window, one slot per output, and reset wait, then hands over to the
// watchdog. It assumes tick is a one-cycle strobe synchronous to clk,
// and that all inputs are synchronous to clk.
module ws_warm_seq
    import ws_pkg::*;
#(
    parameter int NSW        = 5,
    parameter int NREG       = 3,
    parameter int STRAPW     = 2,
    parameter int SLOTW      = 8,
    parameter int CW         = 16,
    parameter int INIT_TICKS = 262,
    parameter int RST_TICKS  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              turn_on,
    input  logic              user_off,
    input  logic              supply_ok,
    input  logic [NSW-1:0]    keep_on,
    input  logic [STRAPW-1:0] straps,
    input  logic [SLOTW-1:0]  slot_ticks,
    input  logic              clk32_req,
    output logic              ws_active,
    output logic [NSW-1:0]    sw_en,
    output logic [NREG-1:0]   reg_en,
    output logic [NSW-1:0]    sw_load,
    output logic [STRAPW-1:0] dflt_sel,
    output logic              sys_rst_n,
    output logic              mcu_rst_n,
    output logic              clk32_out,
    output logic              warm_irq,
    output logic              wdog_go
);
    localparam int N  = NSW + NREG;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST_SLOT = IW'(N - 1);
    localparam logic [CW-1:0] INIT_LIM  = CW'(INIT_TICKS);
    localparam logic [CW-1:0] RST_LIM   = CW'(RST_TICKS);

    ws_state_e          state, nxt;
    logic [IW-1:0]      slot_q, step_idx;
    logic               step, entry, ph_clr, ph_full, rt_full;
    logic [CW-1:0]      ph_lim;
    logic [NSW-1:0]     keep_q;
    logic [SLOTW-1:0]   slot_len_q;
    logic               clk_q, irq_q;
    logic [STRAPW-1:0]  strap_q;
    logic [N-1:0]       en;

    // next-state and slot-step decode
    always_comb begin
        nxt      = state;
        step     = 1'b0;
        step_idx = slot_q;
        unique case (state)
            WS_IDLE:  if (turn_on && user_off) nxt = WS_INIT;
            WS_INIT:  if (ph_full && supply_ok) begin
                          nxt      = WS_SEQ;
                          step     = 1'b1;
                          step_idx = '0;
                      end
            WS_SEQ:   if (ph_full) begin
                          if (slot_q == LAST_SLOT) nxt = WS_RWAIT;
                          else begin
                              step     = 1'b1;
                              step_idx = slot_q + 1'b1;
                          end
                      end
            WS_RWAIT: if (rt_full) nxt = WS_DONE;
            WS_DONE:  nxt = WS_DONE;
            default:  nxt = WS_IDLE;
        endcase
    end

    assign entry  = (state == WS_IDLE) && (nxt == WS_INIT);
    assign ph_clr = (state == WS_IDLE) || (nxt != state) || step;
    assign ph_lim = (state == WS_INIT) ? INIT_LIM : CW'(slot_len_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else state <= nxt;
    end

    // track the slot index of the output most recently enabled
    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else if (step) slot_q <= step_idx;
    end

    // capture keep-on flags, clock request and slot length at entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q     <= '0;
            clk_q      <= 1'b0;
            slot_len_q <= '0;
        end else if (entry) begin
            keep_q     <= keep_on;
            clk_q      <= clk32_req;
            slot_len_q <= slot_ticks;
        end
    end

    // capture the straps when initialisation completes
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= '0;
        else if (state == WS_INIT && nxt == WS_SEQ) strap_q <= straps;
    end

    // one-cycle interrupt on the way into hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else irq_q <= (state == WS_RWAIT) && rt_full;
    end

    ws_tick_timer #(.CW(CW)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .tick(tick),
        .limit(ph_lim), .full(ph_full)
    );

    ws_tick_timer #(.CW(CW)) u_rst_timer (
        .clk(clk), .rst_n(rst_n), .clr(state == WS_IDLE),
        .tick(tick && (state != WS_DONE)),
        .limit(RST_LIM), .full(rt_full)
    );

    ws_enable_chain #(.N(N), .NSW(NSW)) u_chain (
        .clk(clk), .rst_n(rst_n), .clr(state == WS_IDLE),
        .step(step), .idx(step_idx), .en(en), .load(sw_load)
    );

    assign ws_active = (state == WS_INIT) || (state == WS_SEQ) || (state == WS_RWAIT);
    assign sw_en     = (state == WS_IDLE) ? keep_on : (en[NSW-1:0] | keep_q);
    assign reg_en    = en[N-1:NSW];
    assign dflt_sel  = strap_q;
    assign sys_rst_n = (state == WS_DONE);
    assign wdog_go   = (state == WS_DONE);
    assign mcu_rst_n = 1'b1;
    assign clk32_out = (state == WS_IDLE) ? clk32_req : clk_q;
    assign warm_irq  = irq_q;
endmodule

// File: rtl/ws_warm_seq_chk.sv
// Property checker for ws_warm_seq, attached by bind. It assumes a
// synchronous active-low reset and one-cycle tick strobes.
module ws_warm_seq_chk #(
    parameter int NSW  = 5,
    parameter int NREG = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            turn_on,
    input logic            user_off,
    input logic            ws_active,
    input logic [NSW-1:0]  sw_en,
    input logic [NREG-1:0] reg_en,
    input logic [NSW-1:0]  sw_load,
    input logic [NSW-1:0]  keep_q,
    input logic            sys_rst_n,
    input logic            warm_irq,
    input logic            wdog_go
);
    logic pv;

    // mark that the previous cycle was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else pv <= 1'b1;
    end

    // R1
    entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && ws_active && !$past(ws_active) |-> $past(turn_on && user_off));

    // R3
    one_new_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && $past(ws_active) |->
            $onehot0({reg_en, sw_en} & ~$past({reg_en, sw_en})));

    // R4
    kept_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ws_active |-> ((sw_en & keep_q) == keep_q));

    // R5
    load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_load));

    // R6
    reset_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ws_active |-> !sys_rst_n);

    // R8
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_irq |-> sys_rst_n && wdog_go);

    // R8
    irq_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && warm_irq |-> !$past(sys_rst_n));

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_irq |=> !warm_irq);

    // R8
    release_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && sys_rst_n && !$past(sys_rst_n) |-> warm_irq);
endmodule

bind ws_warm_seq ws_warm_seq_chk #(.NSW(NSW), .NREG(NREG)) chk_i (
    .clk(clk), .rst_n(rst_n), .turn_on(turn_on), .user_off(user_off),
    .ws_active(ws_active), .sw_en(sw_en), .reg_en(reg_en),
    .sw_load(sw_load), .keep_q(keep_q), .sys_rst_n(sys_rst_n),
    .warm_irq(warm_irq), .wdog_go(wdog_go)
);

// File: tb/ws_warm_seq_tb_top.sv
// Bench for ws_warm_seq: a behavioural reference model, updated on every
// rising edge, is compared with all outputs on every falling edge.
module ws_warm_seq_tb_top;
    localparam int NSW = 5, NREG = 3, NOUT = 8;
    localparam int INIT_T = 262, RST_T = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, turn_on = 1'b0, user_off = 1'b0, supply_ok = 1'b1;
    logic [4:0] keep_on = '0;
    logic [1:0] straps = '0;
    logic [7:0] slot_ticks = 8'd4;
    logic clk32_req = 1'b0;

    logic       ws_active, sys_rst_n, mcu_rst_n, clk32_out, warm_irq, wdog_go;
    logic [4:0] sw_en, sw_load;
    logic [2:0] reg_en;
    logic [1:0] dflt_sel;

    always #5 clk = ~clk;

    ws_warm_seq dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .turn_on(turn_on),
        .user_off(user_off), .supply_ok(supply_ok), .keep_on(keep_on),
        .straps(straps), .slot_ticks(slot_ticks), .clk32_req(clk32_req),
        .ws_active(ws_active), .sw_en(sw_en), .reg_en(reg_en),
        .sw_load(sw_load), .dflt_sel(dflt_sel), .sys_rst_n(sys_rst_n),
        .mcu_rst_n(mcu_rst_n), .clk32_out(clk32_out), .warm_irq(warm_irq),
        .wdog_go(wdog_go)
    );

    int n_vec = 0, n_bad = 0;
    bit started = 0, tick_rand = 0, tick_const = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 init, 2 slots, 3 reset wait, 4 hand-over
    int m_st = 0, m_ph = 0, m_rt = 0, m_on = 0, m_slot_len = 0;
    logic [4:0] m_keep = '0, m_load = '0;
    logic [1:0] m_strap = '0;
    bit m_clk = 0, m_irq = 0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_rt = 0; m_on = 0; m_slot_len = 0;
            m_keep = '0; m_load = '0; m_strap = '0; m_clk = 0; m_irq = 0;
        end else begin
            int lim, nst;
            bit pfull, rfull, stp;
            lim   = (m_st == 1) ? INIT_T : m_slot_len;
            pfull = (m_ph == lim);
            rfull = (m_rt == RST_T);
            nst   = m_st;
            stp   = 0;
            m_irq = (m_st == 3) && rfull;
            m_load = '0;
            case (m_st)
                0: if (turn_on && user_off) begin
                       nst = 1; m_keep = keep_on; m_clk = clk32_req;
                       m_slot_len = int'(slot_ticks); m_on = 0;
                   end
                1: if (pfull && supply_ok) begin
                       nst = 2; m_on = 1; m_strap = straps; stp = 1;
                   end
                2: if (pfull) begin
                       if (m_on == NOUT) nst = 3;
                       else begin m_on++; stp = 1; end
                   end
                3: if (rfull) nst = 4;
                default: ;
            endcase
            if (stp && m_on <= NSW) m_load = 5'(1 << (m_on - 1));
            if (m_st == 0 || nst != m_st || stp) m_ph = 0;
            else if (tick && m_ph < lim) m_ph++;
            if (m_st == 0) m_rt = 0;
            else if (m_st != 4 && tick && m_rt < RST_T) m_rt++;
            m_st = nst;
        end
    end

    task automatic cmp(string req, string nm, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, nm, act, exp, $time);
        end
    endtask

    // compare every output against the model away from the rising edge
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [7:0] mask;
            mask = 8'((1 << m_on) - 1);
            cmp("R1", "ws_active", int'(ws_active), int'(m_st >= 1 && m_st <= 3));
            cmp("R4", "sw_en", int'(sw_en),
                int'((m_st == 0) ? keep_on : (mask[4:0] | m_keep)));
            cmp("R3", "reg_en", int'(reg_en), int'(mask[7:5]));
            cmp("R5", "sw_load", int'(sw_load), int'(m_load));
            cmp("R2", "dflt_sel", int'(dflt_sel), int'(m_strap));
            cmp("R6", "sys_rst_n", int'(sys_rst_n), int'(m_st == 4));
            cmp("R6", "mcu_rst_n", int'(mcu_rst_n), 1);
            cmp("R7", "clk32_out", int'(clk32_out), int'((m_st == 0) ? clk32_req : m_clk));
            cmp("R8", "warm_irq", int'(warm_irq), int'(m_irq));
            cmp("R8", "wdog_go", int'(wdog_go), int'(m_st == 4));
        end
    end

    // tick generator, changed shortly after each rising edge
    always @(posedge clk) begin
        #2;
        tick <= tick_const ? 1'b1 : (tick_rand ? 1'($urandom_range(0, 1)) : 1'b0);
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(int limit);
        for (int i = 0; i < limit && m_st != 4; i++) cyc(1);
        cyc(4);
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cyc(1);
        // R9: reset state checked by the per-cycle compare
        do_reset();
        cyc(5);
        // R1: turn_on without user_off is ignored
        turn_on = 1'b1; user_off = 1'b0; keep_on = 5'b00110; clk32_req = 1'b1;
        cyc(20);
        turn_on = 1'b0;
        cyc(5);
        // R2 R3 R4 R7: constant ticks, short slots, timer expires after sequence
        tick_const = 1; straps = 2'b10; keep_on = 5'b10010; slot_ticks = 8'd4;
        user_off = 1'b1; turn_on = 1'b1;
        cyc(1);
        turn_on = 1'b0; user_off = 1'b0; keep_on = 5'b00000; clk32_req = 1'b0;
        cyc(100);
        // R1: turn_on during warm start is ignored
        turn_on = 1'b1; user_off = 1'b1;
        cyc(3);
        turn_on = 1'b0; user_off = 1'b0;
        wait_done(5000);
        // R8: hand-over state is stable
        cyc(20);

        // R9: reset mid-run clears everything
        do_reset();
        keep_on = 5'b01001; user_off = 1'b1; turn_on = 1'b1; slot_ticks = 8'd200;
        cyc(1);
        turn_on = 1'b0;
        cyc(600);
        do_reset();

        // R2 R8 R10: random ticks, supply late, long slots so sequence outlasts the timer
        tick_const = 0; tick_rand = 1; supply_ok = 1'b0; straps = 2'b01;
        keep_on = 5'b00000; clk32_req = 1'b1; slot_ticks = 8'd200;
        user_off = 1'b1; turn_on = 1'b1;
        cyc(1);
        turn_on = 1'b0; slot_ticks = 8'd3; straps = 2'b11;
        cyc(700);
        supply_ok = 1'b1;
        cyc(2);
        straps = 2'b00;
        wait_done(20000);

        // R3 R5 R10: one-tick slots, keep-on changed mid-run
        do_reset();
        tick_rand = 0; tick_const = 1; slot_ticks = 8'd1; keep_on = 5'b00001;
        clk32_req = 1'b0; user_off = 1'b1; turn_on = 1'b1;
        cyc(1);
        turn_on = 1'b0; keep_on = 5'b11111; slot_ticks = 8'd50;
        wait_done(5000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule